// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero-Bit Insertion

This block converts a stream of bytes into a serial HDLC line signal, one bit per cycle of the transmit clock that the surrounding system supplies. A frame is offered as a sequence of bytes on a valid/ready byte port. The first byte carries a start marker and the last carries an end marker. The block puts a flag character in front of the frame and another behind it, and it sends every byte least significant bit first. A 0 is inserted after any five consecutive 1 bits of frame content, so that the content can never look like a flag. Between frames, back-to-back flags fill the line.

A frame in progress can be cut off with an abort request. The same happens when the source fails to supply the next byte in time. The block then sends eight consecutive 1 bits with no inserted zeros. After that it holds the line at all ones until a new frame starts. Since every transfer is a whole byte, frame content is always a multiple of eight bits.

Back-pressure works as follows. `in_ready` depends only on internal state and never on `in_valid`. A byte is taken on a rising clock edge when both signals are high. Once a start-marked byte has been offered, the source should keep `in_valid` high with the next byte until the frame ends. A byte slot that finds no valid byte aborts the frame.

Top module: `hdlc_tx_framer`

## Requirements
- R1: During reset `tx_bit` is 1 and `in_ready` is 0. From the first edge after reset the line carries continuous flags. A flag is 0x7E sent LSB first, which gives the bit order 0,1,1,1,1,1,1,0.
- R2: With no frame open, a byte with `in_valid` and `in_sof` high opens a frame. One opening flag is sent first, aligned to the flag fill, and then each accepted byte follows LSB first.
- R3: Inside frame content, a single 0 is inserted after every run of five 1 bits. The run continues across byte boundaries. It restarts on any 0 and on every flag or abort bit.
- R4: After the byte marked with `in_eof` and any zero it needs, exactly one closing flag is sent. The line then returns to flag fill.
- R5: `in_ready` is high for at most one cycle per byte time. It is high only at a byte slot of an open frame, and never while an inserted zero, a flag or an abort is being sent. Each byte is taken exactly once.
- R6: An `abort_req` pulse while a frame is open lets the byte on the line finish, including its inserted zeros. The block then sends eight 1 bits without inserted zeros, accepts no further byte and closes the frame.
- R7: After an abort the line stays at all ones until a new frame starts. That frame starts with an opening flag.
- R8: `abort_req` while no frame is open has no effect on the line.
- R9: If a byte slot of an open frame that has no end marker pending finds `in_valid` low, the frame is aborted as in R6.
- R10: While no frame is open, a byte with `in_valid` high and `in_sof` low is not accepted and does not change the idle pattern.
- R11: Outside an abort and the all-ones idle that follows it, the line never carries more than six consecutive 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock, supplied from outside |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| in_valid | input | 1 | A byte is offered on in_data |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| in_data | input | 8 | Byte to send, LSB first |
| in_sof | input | 1 | Offered byte is the first of a frame |
| in_eof | input | 1 | Offered byte is the last of a frame |
| abort_req | input | 1 | Request to abort the open frame |
| tx_bit | output | 1 | Serial line output |

## Verification
The hardest conditions to reach are where zero insertion meets a symbol boundary. These include a run of ones that spans two bytes, a run that ends exactly on the last data bit just before the closing flag, and an abort that follows a partial run of ones and must not be stuffed. The stimulus picks byte values that produce each of these: a data byte equal to the flag value, 0xFF followed by 0x1F, a final 0xF8, and an abort raised while 0xF0 is being sent. The bench captures every line bit and searches for the expected stuffed pattern, which it builds independently. It checks the bits before the match, the all-ones stretch after an abort and the longest run of ones on the line.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  // Symbol chosen for the next 8-bit line slot.
  typedef enum logic [1:0] {
    SYM_FLAG  = 2'd0,
    SYM_DATA  = 2'd1,
    SYM_ABORT = 2'd2,
    SYM_MARK  = 2'd3
  } sym_e;
endpackage

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_val,
  input  logic bit_is_data,
  output logic stuff_now
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] ones_q;

  assign stuff_now = (ones_q == CW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (stuff_now) begin
      ones_q <= '0;
    end else if (bit_is_data && bit_val) begin
      ones_q <= ones_q + 1'b1;
    end else begin
      ones_q <= '0;
    end
  end
endmodule

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              hold,
  output logic              cur_bit,
  output logic              empty
);
  localparam int LW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [LW-1:0]     left_q;

  assign cur_bit = sh_q[0];
  assign empty   = (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= load_val >> 1;
      left_q <= LW'(BYTE_W - 1);
    end else if (!hold && !empty) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int                BYTE_W   = 8,
  parameter int                RUN_LEN  = 5,
  parameter logic [BYTE_W-1:0] FLAG_PAT = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              abort_req,
  output logic              tx_bit
);
  import hdlc_tx_pkg::*;

  logic              stuff_now;
  logic              ser_empty;
  logic              ser_bit;
  logic              slot;
  logic              end_frame;
  sym_e              pick;
  logic [BYTE_W-1:0] sym_byte;
  logic              emit_val;
  logic              emit_data;

  logic opened;
  logic close_pend;
  logic abort_pend;
  logic mark_idle;
  logic cur_data;

  // A new symbol is loaded when the shifter is empty and no zero is owed.
  assign slot     = ser_empty && !stuff_now;
  assign in_ready = slot && opened && !close_pend && !abort_pend;

  always_comb begin
    pick = SYM_FLAG;
    if (opened) begin
      if (abort_pend)    pick = SYM_ABORT;
      else if (close_pend) pick = SYM_FLAG;
      else if (in_valid)   pick = SYM_DATA;
      else                 pick = SYM_ABORT;   // underrun
    end else if (in_valid && in_sof) begin
      pick = SYM_FLAG;                         // opening flag
    end else if (mark_idle) begin
      pick = SYM_MARK;
    end
  end

  always_comb begin
    unique case (pick)
      SYM_DATA:             sym_byte = in_data;
      SYM_ABORT, SYM_MARK:  sym_byte = '1;
      default:              sym_byte = FLAG_PAT;
    endcase
  end

  assign end_frame = slot && opened && (pick != SYM_DATA);
  assign emit_val  = slot ? sym_byte[0] : ser_bit;
  assign emit_data = slot ? (pick == SYM_DATA) : cur_data;

  hdlc_tx_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_val     (emit_val),
    .bit_is_data (emit_data),
    .stuff_now   (stuff_now)
  );

  hdlc_tx_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (slot),
    .load_val (sym_byte),
    .hold     (stuff_now),
    .cur_bit  (ser_bit),
    .empty    (ser_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bit <= 1'b1;
      cur_data <= 1'b0;
    end else begin
      tx_bit <= stuff_now ? 1'b0 : emit_val;
      if (slot) cur_data <= (pick == SYM_DATA);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opened     <= 1'b0;
      close_pend <= 1'b0;
      abort_pend <= 1'b0;
      mark_idle  <= 1'b0;
    end else begin
      if (slot) begin
        unique case (pick)
          SYM_DATA: close_pend <= in_eof;
          SYM_ABORT: begin
            opened     <= 1'b0;
            close_pend <= 1'b0;
            abort_pend <= 1'b0;
            mark_idle  <= 1'b1;
          end
          SYM_FLAG: begin
            if (opened) begin
              opened     <= 1'b0;
              close_pend <= 1'b0;
            end else if (in_valid && in_sof) begin
              opened    <= 1'b1;
              mark_idle <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (abort_req && opened && !end_frame) abort_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic tx_bit,
  input logic stuff_now,
  input logic ser_empty,
  input logic opened,
  input logic mark_idle
);
  logic [3:0] run_q;
  logic [3:0] run_now;

  assign run_now = tx_bit ? ((run_q == 4'd15) ? 4'd15 : run_q + 4'd1) : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 4'd0;
    else        run_q <= run_now;
  end

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) stuff_now |=> !tx_bit); // R3
  AST_READY_NOT_STUFF: assert property (@(posedge clk) disable iff (!rst_n) stuff_now |-> !in_ready); // R5
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> (opened && ser_empty)); // R5
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) in_ready |=> !in_ready); // R5
  AST_LONG_ONES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (run_now >= 4'd7) |-> mark_idle); // R11
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .tx_bit    (tx_bit),
  .stuff_now (stuff_now),
  .ser_empty (ser_empty),
  .opened    (opened),
  .mark_idle (mark_idle)
);

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       abort_req = 1'b0;
  logic       tx_bit;

  always #2.5 clk = ~clk;   // 200 MHz

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .abort_req(abort_req), .tx_bit(tx_bit)
  );

  localparam logic [7:0] FLAG = 8'h7E;

  int n_chk = 0;
  int n_bad = 0;
  bit cap [8192];
  int cap_n = 0;
  bit cap_on = 1'b0;
  int hs_n = 0;
  bit exp_q [$];
  int exp_ones = 0;

  always @(negedge clk) begin
    if (cap_on && cap_n < 8192) begin
      cap[cap_n] = tx_bit;
      cap_n++;
    end
    if (cap_on && in_valid && in_ready) hs_n++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // ---- expected pattern builders (from the requirements) ----
  task automatic exp_clear(); exp_q.delete(); exp_ones = 0; endtask
  task automatic exp_flag();
    for (int i = 0; i < 8; i++) exp_q.push_back(FLAG[i]);
    exp_ones = 0;
  endtask
  task automatic exp_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(b[i]);
      if (b[i]) exp_ones++; else exp_ones = 0;
      if (exp_ones == 5) begin exp_q.push_back(1'b0); exp_ones = 0; end
    end
  endtask
  task automatic exp_abort();
    for (int i = 0; i < 8; i++) exp_q.push_back(1'b1);
    exp_ones = 0;
  endtask

  function automatic int find_exp(input int from);
    for (int s = from; s + exp_q.size() <= cap_n; s++) begin
      bit m = 1'b1;
      for (int k = 0; k < exp_q.size(); k++) if (cap[s+k] != exp_q[k]) m = 1'b0;
      if (m) return s;
    end
    return -1;
  endfunction

  function automatic int flag_prefix_bad(input int upto);
    int bad = 0;
    for (int i = 0; i < upto; i++) if (cap[i] != FLAG[i%8]) bad++;
    return bad;
  endfunction

  function automatic int max_run(input int from, input int upto);
    int r = 0;
    int m = 0;
    for (int i = from; i < upto; i++) begin
      if (cap[i]) r++; else r = 0;
      if (r > m) m = r;
    end
    return m;
  endfunction

  // ---- stimulus helpers ----
  task automatic do_reset();
    cap_on = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; abort_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    cap_n = 0; hs_n = 0; cap_on = 1'b1;
  endtask

  task automatic push_byte(input logic [7:0] b, input bit sof, input bit eof);
    int waited = 0;
    bit took = 1'b0;
    in_valid = 1'b1; in_data = b; in_sof = sof; in_eof = eof;
    while (!took && waited < 200) begin
      @(negedge clk);
      waited++;
      if (in_ready) took = 1'b1;
    end
    if (!took) chk(1'b0, "R5", "byte never accepted", 0, 1);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // ---- scenarios ----
  task automatic t_reset_fill();
    int bad_ready = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    do_reset();
    repeat (40) begin @(negedge clk); if (in_ready) bad_ready++; end
    chk(flag_prefix_bad(cap_n) == 0, "R1", "flag fill bit errors", flag_prefix_bad(cap_n), 0);
    chk(bad_ready == 0, "R5", "ready outside frame", bad_ready, 0);
  endtask

  task automatic t_plain_frame();
    int idx;
    do_reset();
    repeat (5) @(negedge clk);
    push_byte(8'hA5, 1'b1, 1'b0);
    push_byte(8'h3C, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    exp_clear(); exp_flag(); exp_byte(8'hA5); exp_byte(8'h3C); exp_flag(); exp_flag();
    idx = find_exp(0);
    chk(idx >= 0, "R2", "plain frame found", idx, 0);
    chk(idx % 8 == 0, "R2", "opening flag alignment", idx % 8, 0);
    if (idx >= 0) chk(flag_prefix_bad(idx) == 0, "R1", "idle before frame", flag_prefix_bad(idx), 0);
    chk(hs_n == 2, "R5", "bytes taken", hs_n, 2);
    chk(max_run(0, cap_n) <= 6, "R11", "longest ones run", max_run(0, cap_n), 6);
  endtask

  task automatic t_stuff_frame();
    int idx;
    do_reset();
    repeat (3) @(negedge clk);
    push_byte(8'h7E, 1'b1, 1'b0);
    push_byte(8'hFF, 1'b0, 1'b0);
    push_byte(8'h1F, 1'b0, 1'b0);
    push_byte(8'hF8, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    exp_clear(); exp_flag();
    exp_byte(8'h7E); exp_byte(8'hFF); exp_byte(8'h1F); exp_byte(8'hF8);
    exp_flag(); exp_flag();
    idx = find_exp(0);
    chk(idx >= 0, "R3", "stuffed frame with closing flag", idx, 0);
    chk(idx % 8 == 0, "R4", "frame alignment", idx % 8, 0);
    chk(hs_n == 4, "R5", "bytes taken once each", hs_n, 4);
    chk(max_run(0, cap_n) <= 6, "R11", "longest ones run", max_run(0, cap_n), 6);
  endtask

  task automatic t_abort_then_frame();
    int idx, j, ones_bad, after;
    do_reset();
    repeat (2) @(negedge clk);
    push_byte(8'h11, 1'b1, 1'b0);
    push_byte(8'hF0, 1'b0, 1'b0);
    @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    in_valid = 1'b1; in_data = 8'h33; in_sof = 1'b0; in_eof = 1'b0;   // no start marker
    repeat (60) @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    push_byte(8'h5A, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    exp_clear(); exp_flag(); exp_byte(8'h11); exp_byte(8'hF0); exp_abort();
    idx = find_exp(0);
    chk(idx >= 0, "R6", "data then unstuffed abort", idx, 0);
    after = (idx >= 0) ? idx + exp_q.size() : 0;
    exp_clear(); exp_flag(); exp_byte(8'h5A); exp_flag(); exp_flag();
    j = find_exp(after);
    chk(j >= 0, "R7", "new frame after ones idle", j, 0);
    ones_bad = 0;
    if (j >= 0) for (int i = after; i < j; i++) if (!cap[i]) ones_bad++;
    chk(ones_bad == 0, "R7", "zeros in idle after abort", ones_bad, 0);
    chk(j - after >= 48, "R10", "idle ones span with unmarked byte", j - after, 48);
    chk(hs_n == 3, "R6", "bytes taken (none after abort)", hs_n, 3);
  endtask

  task automatic t_abort_idle();
    do_reset();
    repeat (3) @(negedge clk);
    abort_req = 1'b1;
    repeat (3) @(negedge clk);
    abort_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(flag_prefix_bad(cap_n) == 0, "R8", "abort while idle changed line", flag_prefix_bad(cap_n), 0);
  endtask

  task automatic t_underrun();
    int idx, zeros;
    do_reset();
    repeat (4) @(negedge clk);
    push_byte(8'h81, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    exp_clear(); exp_flag(); exp_byte(8'h81); exp_abort();
    idx = find_exp(0);
    chk(idx >= 0, "R9", "underrun aborts frame", idx, 0);
    zeros = 0;
    if (idx >= 0) for (int i = idx + exp_q.size(); i < cap_n; i++) if (!cap[i]) zeros++;
    chk(zeros == 0, "R9", "line stays ones after underrun", zeros, 0);
  endtask

  task automatic t_no_sof();
    int rdy = 0;
    do_reset();
    in_valid = 1'b1; in_data = 8'h00; in_sof = 1'b0; in_eof = 1'b1;
    repeat (48) begin @(negedge clk); if (in_ready) rdy++; end
    in_valid = 1'b0;
    chk(rdy == 0, "R10", "ready for unmarked byte", rdy, 0);
    chk(flag_prefix_bad(cap_n) == 0, "R10", "idle pattern disturbed", flag_prefix_bad(cap_n), 0);
  endtask

  initial begin
    t_reset_fill();
    t_plain_frame();
    t_stuff_frame();
    t_abort_then_frame();
    t_abort_idle();
    t_underrun();
    t_no_sof();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule